// File: doc/BRIEF.md
# Branch Trace Address Serializer

This block turns per-instruction completion events from a processor pipeline into a real-time trace for a debug port. Every cycle it reports an instruction status code on a 4-bit status bus. When an indirect branch is taken, its 32-bit target address is also queued as a stream of nibbles for a separate 4-bit data bus. The stream starts with a marker nibble that encodes how many address bytes follow. The address nibbles come after it, least significant first.

The nibble stream drains through a FIFO at one nibble per cycle, so the status bus keeps reporting later instructions while an address is still being sent. A control input selects how many address bytes are shown: 2, 3 or 4. If a taken branch arrives and the FIFO cannot hold its whole group, the block raises a stall to the pipeline and reports an idle status until the group fits.

Top module: `trace_serializer`

## Requirements
- R1: A taken branch that is accepted (`instValid=1`, `isBranch=1`, `stall=0`) makes `pst` equal 0x5 in the next cycle.
- R2: A completed non-branch instruction (`instValid=1`, `isBranch=0`) makes `pst` equal 0x1 in the next cycle. A cycle with `instValid=0` makes `pst` equal 0x0 in the next cycle.
- R3: Each accepted branch queues one marker nibble ahead of its address nibbles. The marker is 0x9 for 2 address bytes, 0xA for 3 and 0xB for 4.
- R4: After the marker come 2×bytes address nibbles, taken from `target` starting at bits [3:0] and moving up four bits at a time. No address bits above the selected size are sent.
- R5: On a cycle with `cfgWrite=1`, `cfgSize` code 0, 1 or 2 selects 2, 3 or 4 bytes, starting with branches accepted in the next cycle. Code 3 is ignored and the previous size is kept.
- R6: `ddata` shows one queued nibble per cycle in queue order, starting the cycle after the nibble is queued if the FIFO was empty. `ddata` shows 0x0 on any cycle when the FIFO was empty.
- R7: `pst` keeps reporting new instructions while earlier address nibbles are still draining on `ddata`.
- R8: A group is accepted only if (nibbles held) + (group length) is at most DEPTH, counted before that cycle's drain. A taken branch that does not fit drives `stall=1` in the same cycle and `pst=0x0` in the next cycle. Non-branch instructions never stall.
- R9: Synchronous active-high `rst` empties the FIFO and sets `pst=0x0`, `ddata=0x0` and the 2-byte size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | An instruction completes this cycle |
| isBranch | input | 1 | The completing instruction is a taken indirect branch |
| target | input | 32 | Branch target address |
| cfgWrite | input | 1 | Load `cfgSize` into the address size setting |
| cfgSize | input | 2 | Size code: 0=2 bytes, 1=3 bytes, 2=4 bytes, 3=ignored |
| stall | output | 1 | Pipeline must hold the current branch |
| pst | output | 4 | Instruction status: 0x0 idle or stalled, 0x1 plain, 0x5 taken branch |
| ddata | output | 4 | Trace data nibble: marker or address, 0x0 when empty |

## Verification
The assertions assume that `isBranch` only matters when `instValid` is high. They also assume a stalled branch is presented again on the following cycles, because the pipeline holds it; they do not check what happens if a stalled request is dropped. The stimulus follows both rules: a stalled branch is kept on the inputs, with the same target, until it is accepted. Back-to-back branches are issued in every size mode so the FIFO fills and stalls, and plain instructions and idle cycles are mixed in so the status bus is checked while the queue drains. Configuration writes, including the ignored code, are placed between groups and also on the same cycle as an accepted branch.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 32;
  localparam int MAX_GROUP = ADDR_W / NIB_W + 1;
  localparam int LEN_W     = $clog2(MAX_GROUP + 1);

  typedef enum logic [1:0] {
    SZ_2B = 2'd0,
    SZ_3B = 2'd1,
    SZ_4B = 2'd2
  } size_e;

  localparam logic [NIB_W-1:0] PST_IDLE   = 4'h0;
  localparam logic [NIB_W-1:0] PST_PLAIN  = 4'h1;
  localparam logic [NIB_W-1:0] PST_BRANCH = 4'h5;

  typedef struct packed {
    logic             push;
    logic [LEN_W-1:0] len;
    logic [NIB_W-1:0] marker;
  } trace_strobe_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic             isBranch,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgSize,
  input  logic [LVL_W-1:0] level,
  output logic             stall,
  output logic [NIB_W-1:0] pst,
  output trace_strobe_t    stb
);
  size_e            sizeReg;
  logic [LEN_W-1:0] grpLen;
  logic [NIB_W-1:0] grpMarker;
  logic [LVL_W:0]   need;
  logic             room;

  // group length and marker follow from the size setting
  always_comb begin
    case (sizeReg)
      SZ_3B:   begin grpLen = LEN_W'(7); grpMarker = 4'hA; end
      SZ_4B:   begin grpLen = LEN_W'(9); grpMarker = 4'hB; end
      default: begin grpLen = LEN_W'(5); grpMarker = 4'h9; end
    endcase
  end

  // room is judged on the level before this cycle's drain
  assign need  = {1'b0, level} + (LVL_W + 1)'(grpLen);
  assign room  = need <= (LVL_W + 1)'(DEPTH);
  assign stall = instValid & isBranch & ~room;

  assign stb.push   = instValid & isBranch & room;
  assign stb.len    = grpLen;
  assign stb.marker = grpMarker;

  always_ff @(posedge clk) begin
    if (rst) begin
      sizeReg <= SZ_2B;
      pst     <= PST_IDLE;
    end else begin
      if (cfgWrite && cfgSize != 2'd3) sizeReg <= size_e'(cfgSize);
      if (!instValid)    pst <= PST_IDLE;
      else if (!isBranch) pst <= PST_PLAIN;
      else if (room)      pst <= PST_BRANCH;
      else                pst <= PST_IDLE;
    end
  end
endmodule

// File: rtl/trace_datapath.sv
module trace_datapath
  import trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  trace_strobe_t     stb,
  input  logic [ADDR_W-1:0] target,
  output logic [LVL_W-1:0]  level,
  output logic [NIB_W-1:0]  ddata
);
  logic [NIB_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [NIB_W-1:0] grp [MAX_GROUP];
  logic             pop;
  logic [LVL_W-1:0] addLen;

  // marker first, then address nibbles from the lowest up
  always_comb begin
    grp[0] = stb.marker;
    for (int i = 1; i < MAX_GROUP; i++) grp[i] = target[NIB_W*(i-1) +: NIB_W];
  end

  assign pop    = level != '0;
  assign addLen = stb.push ? LVL_W'(stb.len) : '0;

  always_ff @(posedge clk) begin
    if (stb.push) begin
      for (int i = 0; i < MAX_GROUP; i++) begin
        if (LEN_W'(i) < stb.len) mem[PTR_W'(wrPtr + PTR_W'(i))] <= grp[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
      ddata <= '0;
    end else begin
      ddata <= pop ? mem[rdPtr] : '0;
      if (pop) rdPtr <= rdPtr + PTR_W'(1);
      if (stb.push) wrPtr <= wrPtr + PTR_W'(stb.len);
      level <= level + addLen - (pop ? LVL_W'(1) : LVL_W'(0));
    end
  end
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
  import trace_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  input  logic        isBranch,
  input  logic [31:0] target,
  input  logic        cfgWrite,
  input  logic [1:0]  cfgSize,
  output logic        stall,
  output logic [3:0]  pst,
  output logic [3:0]  ddata
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  trace_strobe_t    stb;
  logic [LVL_W-1:0] level;

  trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .instValid(instValid), .isBranch(isBranch),
    .cfgWrite(cfgWrite), .cfgSize(cfgSize), .level(level),
    .stall(stall), .pst(pst), .stb(stb)
  );

  trace_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .target(target),
    .level(level), .ddata(ddata)
  );
endmodule

// File: rtl/trace_serializer_chk.sv
module trace_serializer_chk (
  input logic       clk,
  input logic       rst,
  input logic       instValid,
  input logic       isBranch,
  input logic       stall,
  input logic [3:0] pst,
  input logic [3:0] ddata
);
  AST_BRANCH_PST: assert property (@(posedge clk) disable iff (rst)
    (instValid && isBranch && !stall) |=> (pst == 4'h5)); // R1
  AST_PLAIN_PST: assert property (@(posedge clk) disable iff (rst)
    (instValid && !isBranch) |=> (pst == 4'h1)); // R2
  AST_IDLE_PST: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> (pst == 4'h0)); // R2
  AST_STALL_PST: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pst == 4'h0)); // R8
  AST_STALL_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
    stall |-> (instValid && isBranch)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pst == 4'h0 && ddata == 4'h0)); // R9
endmodule

bind trace_serializer trace_serializer_chk u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .isBranch(isBranch),
  .stall(stall), .pst(pst), .ddata(ddata)
);

// File: tb/test_trace_serializer.sv
module test_trace_serializer;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0, isBranch = 1'b0, cfgWrite = 1'b0;
  logic [31:0] target = '0;
  logic [1:0]  cfgSize = '0;
  logic        stall;
  logic [3:0]  pst, ddata;

  int checks = 0, failures = 0, cycCount = 0;
  int mSize = 0;
  logic [4:0] q [$];       // {isMarker, nibble}
  logic [31:0] lfsr = 32'h1ACE_B00C;

  trace_serializer #(.DEPTH(DEPTH)) i_trace_serializer (
    .clk(clk), .rst(rst), .instValid(instValid), .isBranch(isBranch),
    .target(target), .cfgWrite(cfgWrite), .cfgSize(cfgSize),
    .stall(stall), .pst(pst), .ddata(ddata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<150000", cycCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycCount);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // one clock: drive at negedge, check stall, model the edge, check outputs
  task automatic cycle(input logic v, input logic b, input logic [31:0] t,
                       input logic cw, input logic [1:0] cs, output logic acc);
    logic stallExp;
    logic [3:0] pstExp, ddExp;
    string ddTag, pstTag;
    int len, bytes;
    instValid = v; isBranch = b; target = t; cfgWrite = cw; cfgSize = cs;
    #1;
    bytes = mSize + 2;
    len = 1 + 2 * bytes;
    stallExp = v && b && (q.size() + len > DEPTH);
    chk("R8 stall", {31'd0, stall}, {31'd0, stallExp});
    acc = v && b && !stallExp;
    if (!v) begin pstExp = 4'h0; pstTag = "R2 idle pst"; end
    else if (!b) begin pstExp = 4'h1; pstTag = "R2 plain pst"; end
    else if (acc) begin pstExp = 4'h5; pstTag = "R1 branch pst"; end
    else begin pstExp = 4'h0; pstTag = "R8 stalled pst"; end
    if (q.size() == 0) begin ddExp = 4'h0; ddTag = "R6 empty ddata"; end
    else begin
      ddExp = q[0][3:0];
      ddTag = q[0][4] ? "R3 marker" : "R4 address nibble";
      void'(q.pop_front());
    end
    if (acc) begin
      q.push_back({1'b1, 4'(9 + mSize)});
      for (int i = 0; i < 2 * bytes; i++) q.push_back({1'b0, t[4*i +: 4]});
    end
    if (cw && cs != 2'd3) mSize = int'(cs);
    @(posedge clk);
    @(negedge clk);
    chk(pstTag, {28'd0, pst}, {28'd0, pstExp});
    chk(ddTag, {28'd0, ddata}, {28'd0, ddExp});
  endtask

  task automatic issue(input logic b, input logic [31:0] t);
    logic acc;
    do cycle(1'b1, b, t, 1'b0, 2'd0, acc); while (b && !acc);
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 32'd0, 1'b0, 2'd0, acc);
  endtask

  task automatic setSize(input logic [1:0] cs);
    logic acc;
    cycle(1'b0, 1'b0, 32'd0, 1'b1, cs, acc);
  endtask

  initial begin
    logic acc;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset pst", {28'd0, pst}, 32'd0);
    chk("R9 reset ddata", {28'd0, ddata}, 32'd0);
    chk("R9 reset stall", {31'd0, stall}, 32'd0);

    // R9: default size is 2 bytes -> marker 0x9 then A[3:0]
    issue(1'b1, 32'hCAFE_1234);
    idle(1);
    chk("R9 default marker", {28'd0, ddata}, 32'h9);
    idle(1);
    chk("R4 lowest nibble first", {28'd0, ddata}, 32'h4);
    idle(4);
    chk("R6 empty after group", {28'd0, ddata}, 32'h0);

    // R7: plain instruction reported while marker drains
    issue(1'b1, 32'h0000_ABCD);
    issue(1'b0, 32'd0);
    chk("R7 pst during drain", {28'd0, pst}, 32'h1);
    chk("R7 ddata marker during plain", {28'd0, ddata}, 32'h9);
    idle(8);

    // sweep every size: back-to-back branches fill the FIFO and stall
    for (int s = 0; s < 3; s++) begin
      setSize(2'(s));
      for (int k = 0; k < 6; k++) issue(1'b1, 32'h1357_9BDF * (k + 1) + 32'(s));
      for (int k = 0; k < 4; k++) begin
        issue(1'b1, 32'hF0E1_D2C3 ^ 32'(k));
        issue(1'b0, 32'd0);
      end
      idle(20);
    end

    // R5: code 3 ignored, earlier 3-byte choice kept
    setSize(2'd1);
    setSize(2'd3);
    issue(1'b1, 32'h89AB_CDEF);
    idle(1);
    chk("R5 code 3 ignored", {28'd0, ddata}, 32'hA);
    idle(10);

    // R5: write on the same cycle as a branch applies to the next one
    setSize(2'd0);
    cycle(1'b1, 1'b1, 32'h7654_3210, 1'b1, 2'd2, acc);
    issue(1'b1, 32'h0F0F_0F0F);
    idle(14);

    // R8: plain instructions never stall with a full FIFO
    setSize(2'd2);
    issue(1'b1, 32'h1111_2222);
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 1'b1, 32'h3333_4444, 1'b0, 2'd0, acc);
      cycle(1'b1, 1'b0, 32'd0, 1'b0, 2'd0, acc);
    end
    idle(20);

    // mixed pseudo-random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = nextRand();
      if (r[7:4] == 4'h0) cycle(1'b0, 1'b0, 32'd0, 1'b1, r[9:8], acc);
      else if (r[2:0] < 3'd3) issue(1'b1, nextRand());
      else if (r[2:0] < 3'd6) issue(1'b0, 32'd0);
      else idle(1);
    end
    idle(20);
    chk("R6 idle after drain", {28'd0, ddata}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule